// File: doc/BRIEF.md
# L1 Address Translation Buffer (Instruction and Data Pair)

A pair of small first-level translation buffers, one for instruction fetch and one for data access, with no state shared between them. Each side holds a few fully associative entries. A lookup takes a 32-bit effective address and an address-space/process tag and, on a hit, returns a 36-bit physical address in the same cycle. The physical address joins the entry's real page number with the untranslated offset bits of the effective address. The page size of each entry runs from 4 KB to 4 GB.

On a miss the side raises a translation request toward a unified second-level buffer and echoes the address and tag. The requester stalls until that level answers on the refill port. A refill is a valid/ready transfer carrying tag, effective page, real page number and size code. The new entry goes into the lowest-numbered free slot, or if there is none over the least recently used slot. Recency is kept exactly, with an age matrix. A one-cycle invalidate clears a side.

Top module: `l1_xlate_dual`

## Requirements
- R1: After reset every entry of both sides is invalid, so the first lookups miss.
- R2: A lookup hits only on a valid entry whose tag equals the lookup tag and whose stored effective page equals the lookup address above the page offset.
- R3: On a hit, bit positions below the offset width come from the effective address and the rest from the real page number shifted left by 12. Size code k gives 12+2k offset bits, and codes above 10 are treated as 10 (32 offset bits).
- R4: `lk_miss_o` is high exactly when a request does not hit, and it then echoes the lookup address and tag. Hit and miss are never high together, and neither is high without a request.
- R5: A refill is taken when `fill_valid_i` and `fill_ready_o` are both high. `fill_ready_o` is low only in a cycle in which that side's invalidate is high.
- R6: A lookup in the cycle after a refill is taken hits on the refilled entry.
- R7: A refill goes to the lowest-numbered invalid slot if one exists, otherwise to the least recently used slot. Both hits and refills make an entry most recently used, and the order is exact, not a tree approximation.
- R8: Invalidate clears every valid bit of its side and resets its recency order. A refill offered in the same cycle is dropped.
- R9: The two sides are independent: an entry refilled into one is never seen by the other, and both may hit in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| inv_i | input | N_SIDE | Invalidate all entries, per side |
| lk_req_i | input | N_SIDE | Lookup request, per side |
| lk_ea_i | input | N_SIDE x 32 | Effective address |
| lk_tag_i | input | N_SIDE x TAG_W | Address-space/process tag |
| lk_hit_o | output | N_SIDE | Lookup hit |
| lk_pa_o | output | N_SIDE x 36 | Physical address, valid with hit |
| lk_miss_o | output | N_SIDE | Miss: request to second level, requester stalls |
| miss_ea_o | output | N_SIDE x 32 | Address of the missing lookup |
| miss_tag_o | output | N_SIDE x TAG_W | Tag of the missing lookup |
| fill_valid_i | input | N_SIDE | Refill offered |
| fill_ready_o | output | N_SIDE | Refill can be taken |
| fill_tag_i | input | N_SIDE x TAG_W | Refill tag |
| fill_epn_i | input | N_SIDE x 32 | Refill effective page (offset bits ignored) |
| fill_rpn_i | input | N_SIDE x 24 | Refill real page number |
| fill_size_i | input | N_SIDE x 4 | Refill size code |

## Verification
The assertions check the following on every cycle. Hit and miss exclude each other, and a hit needs a request. The low 12 physical bits always pass through from the address. A lookup matching the previous cycle's taken refill must hit, and no lookup hits in the cycle after an invalidate. Only the bench scenarios can show which entry a refill evicts. They cover an exact-LRU touch order that a tree approximation would resolve differently, as well as page-size masking and the size-code clamp. They also show that a refill offered during invalidate is dropped, and that a refill on one side stays invisible to the other.

// File: rtl/xlate_pkg.sv
`timescale 1ns/1ps
package xlate_pkg;
  localparam int EA_W    = 32;
  localparam int PA_W    = 36;
  localparam int OFF_MIN = 12;
  localparam int RPN_W   = PA_W - OFF_MIN;
  localparam int SZ_W    = 4;
  localparam int SZ_MAX  = 10;

  // offset mask: 12 + 2k bits, k clamped to SZ_MAX
  function automatic logic [EA_W-1:0] off_mask(input logic [SZ_W-1:0] sz);
    int unsigned k;
    int unsigned bits;
    k    = (int'(sz) > SZ_MAX) ? SZ_MAX : int'(sz);
    bits = OFF_MIN + 2 * k;
    if (bits >= EA_W) off_mask = '1;
    else              off_mask = (EA_W'(1) << bits) - EA_W'(1);
  endfunction
endpackage

// File: rtl/xlate_cam.sv
`timescale 1ns/1ps
module xlate_cam
  import xlate_pkg::*;
#(
  parameter  int N_ENT = 4,
  parameter  int TAG_W = 9,
  localparam int IDX_W = $clog2(N_ENT)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [TAG_W-1:0] wr_tag_i,
  input  logic [EA_W-1:0]  wr_epn_i,
  input  logic [RPN_W-1:0] wr_rpn_i,
  input  logic [SZ_W-1:0]  wr_sz_i,
  input  logic [EA_W-1:0]  lk_ea_i,
  input  logic [TAG_W-1:0] lk_tag_i,
  output logic             match_o,
  output logic [IDX_W-1:0] match_idx_o,
  output logic [PA_W-1:0]  pa_o,
  output logic [N_ENT-1:0] valid_o
);
  logic [N_ENT-1:0] valid_q;
  logic [TAG_W-1:0] tag_q  [N_ENT];
  logic [EA_W-1:0]  epn_q  [N_ENT];
  logic [EA_W-1:0]  mask_q [N_ENT];
  logic [RPN_W-1:0] rpn_q  [N_ENT];
  logic [N_ENT-1:0] hit_vec;
  logic [EA_W-1:0]  wr_mask;

  assign wr_mask = off_mask(wr_sz_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      valid_q <= '0;
    else if (clr_i)   valid_q <= '0;
    else if (wr_en_i) valid_q[wr_idx_i] <= 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i && !clr_i) begin
      tag_q[wr_idx_i]  <= wr_tag_i;
      mask_q[wr_idx_i] <= wr_mask;
      epn_q[wr_idx_i]  <= wr_epn_i & ~wr_mask;
      rpn_q[wr_idx_i]  <= wr_rpn_i;
    end
  end

  for (genvar i = 0; i < N_ENT; i++) begin : g_cmp
    assign hit_vec[i] = valid_q[i] && (tag_q[i] == lk_tag_i) &&
                        ((lk_ea_i & ~mask_q[i]) == epn_q[i]);
  end

  always_comb begin
    match_idx_o = '0;
    for (int i = N_ENT - 1; i >= 0; i--)
      if (hit_vec[i]) match_idx_o = IDX_W'(i);
  end

  logic [EA_W-1:0]  sel_mask;
  logic [RPN_W-1:0] sel_rpn;
  assign sel_mask = mask_q[match_idx_o];
  assign sel_rpn  = rpn_q[match_idx_o];

  assign match_o = |hit_vec;
  assign pa_o    = ({sel_rpn, {OFF_MIN{1'b0}}} & ~{{(PA_W-EA_W){1'b0}}, sel_mask}) |
                   {{(PA_W-EA_W){1'b0}}, lk_ea_i & sel_mask};
  assign valid_o = valid_q;
endmodule

// File: rtl/xlate_lru.sv
`timescale 1ns/1ps
module xlate_lru #(
  parameter  int N_ENT = 4,
  localparam int IDX_W = $clog2(N_ENT)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             hit_v_i,
  input  logic [IDX_W-1:0] hit_idx_i,
  input  logic             fill_v_i,
  input  logic [IDX_W-1:0] fill_idx_i,
  output logic [IDX_W-1:0] lru_idx_o
);
  // age_q[i][j] = 1: entry i used more recently than entry j
  logic [N_ENT-1:0] age_q [N_ENT];
  logic [N_ENT-1:0] age_d [N_ENT];
  logic [N_ENT-1:0] hit_oh, fill_oh;

  function automatic logic [N_ENT-1:0] init_row(input int r);
    logic [N_ENT-1:0] v;
    for (int j = 0; j < N_ENT; j++) v[j] = (j < r);
    return v;
  endfunction

  assign hit_oh  = N_ENT'(1) << hit_idx_i;
  assign fill_oh = N_ENT'(1) << fill_idx_i;

  always_comb begin
    for (int i = 0; i < N_ENT; i++) age_d[i] = age_q[i];
    if (hit_v_i) begin
      for (int i = 0; i < N_ENT; i++) age_d[i] = age_d[i] & ~hit_oh;
      age_d[hit_idx_i] = ~hit_oh;
    end
    if (fill_v_i) begin
      for (int i = 0; i < N_ENT; i++) age_d[i] = age_d[i] & ~fill_oh;
      age_d[fill_idx_i] = ~fill_oh;
    end
    if (clr_i)
      for (int i = 0; i < N_ENT; i++) age_d[i] = init_row(i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N_ENT; i++) age_q[i] <= init_row(i);
    end else begin
      for (int i = 0; i < N_ENT; i++) age_q[i] <= age_d[i];
    end
  end

  always_comb begin
    lru_idx_o = '0;
    for (int i = N_ENT - 1; i >= 0; i--)
      if (age_q[i] == '0) lru_idx_o = IDX_W'(i);
  end
endmodule

// File: rtl/xlate_side.sv
`timescale 1ns/1ps
module xlate_side
  import xlate_pkg::*;
#(
  parameter  int N_ENT = 4,
  parameter  int TAG_W = 9,
  localparam int IDX_W = $clog2(N_ENT)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inv_i,
  input  logic             lk_req_i,
  input  logic [EA_W-1:0]  lk_ea_i,
  input  logic [TAG_W-1:0] lk_tag_i,
  output logic             lk_hit_o,
  output logic [PA_W-1:0]  lk_pa_o,
  output logic             lk_miss_o,
  output logic [EA_W-1:0]  miss_ea_o,
  output logic [TAG_W-1:0] miss_tag_o,
  input  logic             fill_valid_i,
  output logic             fill_ready_o,
  input  logic [TAG_W-1:0] fill_tag_i,
  input  logic [EA_W-1:0]  fill_epn_i,
  input  logic [RPN_W-1:0] fill_rpn_i,
  input  logic [SZ_W-1:0]  fill_size_i
);
  logic             match;
  logic [IDX_W-1:0] match_idx, lru_idx, victim;
  logic [N_ENT-1:0] valid;
  logic             fill_fire;
  logic             any_free;
  logic [IDX_W-1:0] free_idx;

  assign fill_ready_o = !inv_i;
  assign fill_fire    = fill_valid_i && fill_ready_o;

  always_comb begin
    any_free = 1'b0;
    free_idx = '0;
    for (int i = N_ENT - 1; i >= 0; i--)
      if (!valid[i]) begin
        any_free = 1'b1;
        free_idx = IDX_W'(i);
      end
  end
  assign victim = any_free ? free_idx : lru_idx;

  xlate_cam #(.N_ENT(N_ENT), .TAG_W(TAG_W)) u_cam (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (inv_i),
    .wr_en_i     (fill_fire),
    .wr_idx_i    (victim),
    .wr_tag_i    (fill_tag_i),
    .wr_epn_i    (fill_epn_i),
    .wr_rpn_i    (fill_rpn_i),
    .wr_sz_i     (fill_size_i),
    .lk_ea_i     (lk_ea_i),
    .lk_tag_i    (lk_tag_i),
    .match_o     (match),
    .match_idx_o (match_idx),
    .pa_o        (lk_pa_o),
    .valid_o     (valid)
  );

  xlate_lru #(.N_ENT(N_ENT)) u_lru (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (inv_i),
    .hit_v_i    (lk_hit_o),
    .hit_idx_i  (match_idx),
    .fill_v_i   (fill_fire),
    .fill_idx_i (victim),
    .lru_idx_o  (lru_idx)
  );

  assign lk_hit_o   = lk_req_i && match;
  assign lk_miss_o  = lk_req_i && !match;
  assign miss_ea_o  = lk_ea_i;
  assign miss_tag_o = lk_tag_i;
endmodule

// File: rtl/l1_xlate_dual.sv
`timescale 1ns/1ps
module l1_xlate_dual
  import xlate_pkg::*;
#(
  parameter int N_SIDE = 2,
  parameter int N_ENT  = 4,
  parameter int TAG_W  = 9
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [N_SIDE-1:0]             inv_i,
  input  logic [N_SIDE-1:0]             lk_req_i,
  input  logic [N_SIDE-1:0][EA_W-1:0]   lk_ea_i,
  input  logic [N_SIDE-1:0][TAG_W-1:0]  lk_tag_i,
  output logic [N_SIDE-1:0]             lk_hit_o,
  output logic [N_SIDE-1:0][PA_W-1:0]   lk_pa_o,
  output logic [N_SIDE-1:0]             lk_miss_o,
  output logic [N_SIDE-1:0][EA_W-1:0]   miss_ea_o,
  output logic [N_SIDE-1:0][TAG_W-1:0]  miss_tag_o,
  input  logic [N_SIDE-1:0]             fill_valid_i,
  output logic [N_SIDE-1:0]             fill_ready_o,
  input  logic [N_SIDE-1:0][TAG_W-1:0]  fill_tag_i,
  input  logic [N_SIDE-1:0][EA_W-1:0]   fill_epn_i,
  input  logic [N_SIDE-1:0][RPN_W-1:0]  fill_rpn_i,
  input  logic [N_SIDE-1:0][SZ_W-1:0]   fill_size_i
);
  // one private buffer per side, nothing shared
  for (genvar s = 0; s < N_SIDE; s++) begin : g_side
    xlate_side #(.N_ENT(N_ENT), .TAG_W(TAG_W)) u_side (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .inv_i        (inv_i[s]),
      .lk_req_i     (lk_req_i[s]),
      .lk_ea_i      (lk_ea_i[s]),
      .lk_tag_i     (lk_tag_i[s]),
      .lk_hit_o     (lk_hit_o[s]),
      .lk_pa_o      (lk_pa_o[s]),
      .lk_miss_o    (lk_miss_o[s]),
      .miss_ea_o    (miss_ea_o[s]),
      .miss_tag_o   (miss_tag_o[s]),
      .fill_valid_i (fill_valid_i[s]),
      .fill_ready_o (fill_ready_o[s]),
      .fill_tag_i   (fill_tag_i[s]),
      .fill_epn_i   (fill_epn_i[s]),
      .fill_rpn_i   (fill_rpn_i[s]),
      .fill_size_i  (fill_size_i[s])
    );
  end
endmodule

// File: rtl/xlate_chk.sv
`timescale 1ns/1ps
module xlate_chk
  import xlate_pkg::*;
#(
  parameter int N_SIDE = 2,
  parameter int TAG_W  = 9
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic [N_SIDE-1:0]             inv_i,
  input logic [N_SIDE-1:0]             lk_req_i,
  input logic [N_SIDE-1:0][EA_W-1:0]   lk_ea_i,
  input logic [N_SIDE-1:0][TAG_W-1:0]  lk_tag_i,
  input logic [N_SIDE-1:0]             lk_hit_o,
  input logic [N_SIDE-1:0][PA_W-1:0]   lk_pa_o,
  input logic [N_SIDE-1:0]             lk_miss_o,
  input logic [N_SIDE-1:0]             fill_valid_i,
  input logic [N_SIDE-1:0]             fill_ready_o,
  input logic [N_SIDE-1:0][TAG_W-1:0]  fill_tag_i,
  input logic [N_SIDE-1:0][EA_W-1:0]   fill_epn_i
);
  for (genvar s = 0; s < N_SIDE; s++) begin : g_chk
    // R4
    hit_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      lk_hit_o[s] |-> (lk_req_i[s] && !lk_miss_o[s]));

    // R4
    miss_needs_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      lk_miss_o[s] |-> lk_req_i[s]);

    // R3
    pa_offset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      lk_hit_o[s] |-> (lk_pa_o[s][OFF_MIN-1:0] == lk_ea_i[s][OFF_MIN-1:0]));

    // R6
    fill_next_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (lk_req_i[s] && $past(fill_valid_i[s] && fill_ready_o[s]) &&
       lk_tag_i[s] == $past(fill_tag_i[s]) && lk_ea_i[s] == $past(fill_epn_i[s]))
      |-> lk_hit_o[s]);

    // R8
    inv_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(inv_i[s]) && lk_req_i[s]) |-> !lk_hit_o[s]);
  end
endmodule

bind l1_xlate_dual xlate_chk #(.N_SIDE(N_SIDE), .TAG_W(TAG_W)) u_xlate_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .inv_i        (inv_i),
  .lk_req_i     (lk_req_i),
  .lk_ea_i      (lk_ea_i),
  .lk_tag_i     (lk_tag_i),
  .lk_hit_o     (lk_hit_o),
  .lk_pa_o      (lk_pa_o),
  .lk_miss_o    (lk_miss_o),
  .fill_valid_i (fill_valid_i),
  .fill_ready_o (fill_ready_o),
  .fill_tag_i   (fill_tag_i),
  .fill_epn_i   (fill_epn_i)
);

// File: tb/l1_xlate_dual_bench.sv
`timescale 1ns/1ps
module l1_xlate_dual_bench;
  localparam int NS = 2;
  localparam int TW = 9;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic [NS-1:0]        inv = '0;
  logic [NS-1:0]        lk_req = '0;
  logic [NS-1:0][31:0]  lk_ea = '0;
  logic [NS-1:0][TW-1:0] lk_tag = '0;
  logic [NS-1:0]        lk_hit;
  logic [NS-1:0][35:0]  lk_pa;
  logic [NS-1:0]        lk_miss;
  logic [NS-1:0][31:0]  miss_ea;
  logic [NS-1:0][TW-1:0] miss_tag;
  logic [NS-1:0]        fill_valid = '0;
  logic [NS-1:0]        fill_ready;
  logic [NS-1:0][TW-1:0] fill_tag = '0;
  logic [NS-1:0][31:0]  fill_epn = '0;
  logic [NS-1:0][23:0]  fill_rpn = '0;
  logic [NS-1:0][3:0]   fill_size = '0;

  int total = 0;
  int bad   = 0;

  always #10 clk = ~clk; // 50 MHz

  l1_xlate_dual #(.N_SIDE(NS), .N_ENT(4), .TAG_W(TW)) u_l1_xlate_dual (
    .clk_i (clk), .rst_ni (rst_n), .inv_i (inv),
    .lk_req_i (lk_req), .lk_ea_i (lk_ea), .lk_tag_i (lk_tag),
    .lk_hit_o (lk_hit), .lk_pa_o (lk_pa), .lk_miss_o (lk_miss),
    .miss_ea_o (miss_ea), .miss_tag_o (miss_tag),
    .fill_valid_i (fill_valid), .fill_ready_o (fill_ready),
    .fill_tag_i (fill_tag), .fill_epn_i (fill_epn),
    .fill_rpn_i (fill_rpn), .fill_size_i (fill_size)
  );

  typedef struct {
    int          side;
    bit          is_rdy;
    bit          exp_rdy;
    bit          req;
    bit          exp_hit;
    bit [35:0]   exp_pa;
    bit [31:0]   ea;
    bit [TW-1:0] tag;
    string       rq;
  } item_t;

  item_t sb[$];

  task automatic tick();
    @(negedge clk);
  endtask

  // drive a lookup and queue its expected result
  task automatic lk(int s, bit req, bit [31:0] ea, bit [TW-1:0] tag,
                    bit eh, bit [35:0] pa, string rq);
    item_t it;
    lk_req[s] = req; lk_ea[s] = ea; lk_tag[s] = tag;
    it.side = s; it.is_rdy = 0; it.exp_rdy = 0; it.req = req; it.exp_hit = eh;
    it.exp_pa = pa; it.ea = ea; it.tag = tag; it.rq = rq;
    sb.push_back(it);
  endtask

  task automatic exp_rdy(int s, bit r, string rq);
    item_t it;
    it.side = s; it.is_rdy = 1; it.exp_rdy = r; it.req = 0; it.exp_hit = 0;
    it.exp_pa = '0; it.ea = '0; it.tag = '0; it.rq = rq;
    sb.push_back(it);
  endtask

  task automatic fill(int s, bit [TW-1:0] tag, bit [31:0] epn, bit [23:0] rpn, bit [3:0] sz);
    fill_valid[s] = 1'b1; fill_tag[s] = tag; fill_epn[s] = epn;
    fill_rpn[s] = rpn; fill_size[s] = sz;
  endtask

  task automatic idle(int s);
    fill_valid[s] = 1'b0; lk_req[s] = 1'b0;
  endtask

  // monitor: compare queued expectations mid low phase
  always @(negedge clk) begin
    #5;
    while (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      total++;
      if (it.is_rdy) begin
        if (fill_ready[it.side] !== it.exp_rdy) begin
          bad++;
          $display("FAIL %s side%0d ready act=%b exp=%b", it.rq, it.side,
                   fill_ready[it.side], it.exp_rdy);
        end
      end else begin
        bit em;
        em = it.req && !it.exp_hit;
        if (lk_hit[it.side] !== it.exp_hit || lk_miss[it.side] !== em) begin
          bad++;
          $display("FAIL %s side%0d hit/miss act=%b/%b exp=%b/%b", it.rq, it.side,
                   lk_hit[it.side], lk_miss[it.side], it.exp_hit, em);
        end else if (it.exp_hit && lk_pa[it.side] !== it.exp_pa) begin
          bad++;
          $display("FAIL %s side%0d pa act=%h exp=%h", it.rq, it.side,
                   lk_pa[it.side], it.exp_pa);
        end else if (em && (miss_ea[it.side] !== it.ea || miss_tag[it.side] !== it.tag)) begin
          bad++;
          $display("FAIL %s side%0d miss echo act=%h/%h exp=%h/%h", it.rq, it.side,
                   miss_ea[it.side], miss_tag[it.side], it.ea, it.tag);
        end
      end
    end
  end

  initial begin
    #(20 * 200000);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;

    // R1 reset: both sides miss; R5 ready high
    tick();
    lk(0, 1, 32'h1000_0123, 9'd5, 0, '0, "R1");
    lk(1, 1, 32'h1000_0123, 9'd5, 0, '0, "R1");
    exp_rdy(0, 1, "R5");
    exp_rdy(1, 1, "R5");

    // R4 stall during refill cycle, R6 hit next cycle
    tick();
    idle(1);
    fill(0, 9'd5, 32'h1000_0000, 24'h0ABCDE, 4'd0);
    lk(0, 1, 32'h1000_0123, 9'd5, 0, '0, "R4");
    tick();
    fill_valid[0] = 1'b0;
    lk(0, 1, 32'h1000_0123, 9'd5, 1, 36'h0ABCDE123, "R6");
    lk(1, 1, 32'h1000_0123, 9'd5, 0, '0, "R9");
    tick();
    idle(1);
    lk(0, 1, 32'h1000_0123, 9'd6, 0, '0, "R2");
    tick();
    lk(0, 1, 32'h1000_1123, 9'd5, 0, '0, "R2");

    // R3 64 KB page (code 2 -> 16 offset bits)
    tick();
    fill(0, 9'd5, 32'h4000_0000, 24'h123456, 4'd2);
    lk(0, 0, 32'h0, 9'd0, 0, '0, "R4");
    tick();
    fill_valid[0] = 1'b0;
    lk(0, 1, 32'h4000_BEEF, 9'd5, 1, 36'h1_2345_BEEF, "R3");
    tick();
    lk(0, 1, 32'h4001_0000, 9'd5, 0, '0, "R2");

    // R3 size clamp on side 1: code 15 -> 32 offset bits
    tick();
    idle(0);
    fill(1, 9'd3, 32'h8000_0000, 24'hA00000, 4'd15);
    tick();
    fill_valid[1] = 1'b0;
    lk(1, 1, 32'h1234_5678, 9'd3, 1, 36'hA_1234_5678, "R3");
    lk(0, 1, 32'h1000_0456, 9'd5, 1, 36'h0ABCDE456, "R9");

    // R8 invalidate drops concurrent refill, side 1 unaffected
    tick();
    idle(0);
    inv[0] = 1'b1;
    fill(0, 9'd5, 32'h5000_0000, 24'h000001, 4'd0);
    exp_rdy(0, 0, "R5");
    lk(1, 1, 32'h0000_0000, 9'd3, 1, 36'hA_0000_0000, "R9");
    tick();
    inv[0] = 1'b0;
    fill_valid[0] = 1'b0;
    idle(1);
    lk(0, 1, 32'h1000_0123, 9'd5, 0, '0, "R8");
    exp_rdy(0, 1, "R5");
    tick();
    lk(0, 1, 32'h5000_0000, 9'd5, 0, '0, "R8");

    // R7 fill four free slots, then touch 1,0,3 -> exact LRU is slot 2
    for (int i = 0; i < 4; i++) begin
      tick();
      lk_req[0] = 1'b0;
      fill(0, 9'd5, 32'h2000_0000 + (i << 12), 24'h000100 + 24'(i), 4'd0);
      tick();
      fill_valid[0] = 1'b0;
    end
    tick();
    lk(0, 1, 32'h2000_1010, 9'd5, 1, 36'h000101010, "R7");
    tick();
    lk(0, 1, 32'h2000_0020, 9'd5, 1, 36'h000100020, "R7");
    tick();
    lk(0, 1, 32'h2000_3030, 9'd5, 1, 36'h000103030, "R7");
    tick();
    lk_req[0] = 1'b0;
    fill(0, 9'd5, 32'h2000_4000, 24'h000104, 4'd0);
    tick();
    fill_valid[0] = 1'b0;
    lk(0, 1, 32'h2000_2000, 9'd5, 0, '0, "R7");
    tick();
    lk(0, 1, 32'h2000_1ABC, 9'd5, 1, 36'h000101ABC, "R7");
    tick();
    lk(0, 1, 32'h2000_0ABC, 9'd5, 1, 36'h000100ABC, "R7");
    tick();
    lk(0, 1, 32'h2000_3ABC, 9'd5, 1, 36'h000103ABC, "R7");
    tick();
    lk(0, 1, 32'h2000_4444, 9'd5, 1, 36'h000104444, "R7");

    tick();
    idle(0);
    tick();
    tick();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule